// File: doc/BRIEF.md
# SDRAM initialisation and refresh sequencer

This block brings an SDRAM out of reset and then keeps its contents alive. After reset it waits a programmable settling time, closes every bank, runs a fixed set of AUTO REFRESH commands and loads the mode register. After that it counts the refresh interval. Each time the interval expires it asks the command scheduler for the bus. Refreshes that come due while the scheduler is busy are counted and later paid back one after another. The block also puts the memory into self refresh by dropping the clock enable, and it brings the memory back out of it.

The sequencer never takes the bus by itself. It raises `busy` to ask for the bus. The scheduler grants the bus only after it has precharged all banks. A command leaves the block only after an edge at which `grant` was high. Every command is registered and spaced by the timing parameters (precharge time, row cycle time, mode-register delay), so the scheduler can forward the command bus without changes.

Top module: `sdram_upkeep_seq`

## Requirements
- R1: While in reset and for INIT_WAIT clocks after it, the outputs are: `cmd` NOP (4'b0111), `cke` high, `done` low, `busy` high. No other command appears.
- R2: The first command is PRECHARGE ALL (`cmd` 4'b0010 with `addr` bit 10 set). It is followed by INIT_REFS AUTO REFRESH commands (`cmd` 4'b0001). The first of these comes TRP clocks after the precharge, and the rest are TRC clocks apart.
- R3: TRC clocks after the last start-up refresh, MODE REGISTER SET (`cmd` 4'b0000) is issued. Its `addr` carries CAS latency in bits 6:4, wrap type in bit 3 (1 = interleaved) and log2 of the burst length in bits 2:0. `done` rises TMRD clocks later and stays high.
- R4: A command other than NOP appears only in the cycle after an edge at which `grant` was high. Otherwise the block waits and drives NOP.
- R5: Once `done` is high, a refresh becomes owed every REFI clocks, and `busy` is high whenever a refresh is owed.
- R6: Owed refreshes are issued back to back, TRC clocks apart, until none is owed. Two missed deadlines give two consecutive refreshes.
- R7: With `sleep_req` high and nothing owed, the block asks for the bus. On grant it issues 4'b0001 with `cke` low in the same cycle. It then drives only NOP and clears the owed count.
- R8: When `sleep_req` falls during self refresh, `cke` rises on the next clock. `busy` stays high and no command is issued for TRC+2 clocks from that point.
- R9: `sleep_req` is ignored until `done` is high: `cke` stays high.
- R10: The owed count saturates at MAX_OWED, so a long stall is repaid with exactly MAX_OWED refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Scheduler hands over the bus, all banks precharged |
| sleep_req | input | 1 | Request to enter (high) or leave (low) self refresh |
| cmd | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| addr | output | ADDR_W | Address bus for the command |
| cke | output | 1 | Clock enable to the memory |
| done | output | 1 | Start-up sequence complete |
| busy | output | 1 | Bus request to the scheduler |

## Verification
The bench first holds `grant` low across the settling time. This shows whether the start-up sequence stalls correctly and whether it still orders precharge, eight refreshes and the mode load. With the grant left open, the plain refresh cadence is measured. With the grant held low for two intervals, the check tells catch-up repayment apart from a single refresh. With the grant held low for many intervals, a saturating owed counter is told apart from one that wraps. A self-refresh visit with a long stay shows that refresh stops, that the owed count is cleared, and that the exit window holds back the bus.

// File: rtl/sdram_upkeep_seq.sv
module sdram_upkeep_seq #(
  parameter int INIT_WAIT  = 13334,
  parameter int REFI       = 2083,
  parameter int TRC        = 8,
  parameter int TRP        = 3,
  parameter int TMRD       = 2,
  parameter int INIT_REFS  = 8,
  parameter int MAX_OWED   = 8,
  parameter int ADDR_W     = 12,
  parameter int CAS_LAT    = 3,
  parameter int BURST_LEN  = 8,
  parameter int INTERLEAVE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  logic              sleep_req,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              cke,
  output logic              done,
  output logic              busy
);
  localparam int GAP_MAX = (INIT_WAIT > TRC + 2) ? INIT_WAIT : TRC + 2;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int TICK_W  = $clog2(REFI);
  localparam int OWE_W   = $clog2(MAX_OWED + 1);
  localparam int LEFT_W  = $clog2(INIT_REFS + 1);
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'((CAS_LAT << 4) | (INTERLEAVE << 3) | $clog2(BURST_LEN));
  localparam logic [3:0] C_NOP = 4'b0111, C_PALL = 4'b0010,
                         C_AREF = 4'b0001, C_MRS = 4'b0000;

  typedef enum logic [2:0] {S_PRE, S_IREF, S_MRS, S_SETTLE,
                            S_IDLE, S_AREF, S_SREN, S_SELF} state_t;

  state_t              state;
  logic [GAP_W-1:0]    gap;
  logic [TICK_W-1:0]   tick;
  logic [OWE_W-1:0]    owed, owed_nx;
  logic [LEFT_W-1:0]   left;
  logic [3:0]          cmd_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                cke_q, done_q;
  logic                fire, tick_en, tick_hit, dec, clr;

  assign fire     = grant && (gap == '0);
  assign tick_en  = done_q && cke_q;
  assign tick_hit = tick_en && (tick == '0);
  assign dec      = (state == S_AREF) && fire;
  assign clr      = (state == S_SREN) && fire;

  always_comb begin
    owed_nx = owed - OWE_W'(dec);
    if (tick_hit && owed_nx != OWE_W'(MAX_OWED)) owed_nx = owed_nx + 1'b1;
    if (clr) owed_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_PRE;
      gap    <= GAP_W'(INIT_WAIT);
      tick   <= TICK_W'(REFI - 1);
      owed   <= '0;
      left   <= '0;
      cmd_q  <= C_NOP;
      addr_q <= '0;
      cke_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= C_NOP;
      addr_q <= '0;
      owed   <= owed_nx;
      if (gap != '0) gap <= gap - 1'b1;
      if (clr || tick_hit) tick <= TICK_W'(REFI - 1);
      else if (tick_en)    tick <= tick - 1'b1;
      case (state)
        S_PRE: if (fire) begin
          cmd_q      <= C_PALL;
          addr_q[10] <= 1'b1;
          gap        <= GAP_W'(TRP - 1);
          left       <= LEFT_W'(INIT_REFS);
          state      <= S_IREF;
        end
        S_IREF: if (fire) begin
          cmd_q <= C_AREF;
          gap   <= GAP_W'(TRC - 1);
          left  <= left - 1'b1;
          if (left == LEFT_W'(1)) state <= S_MRS;
        end
        S_MRS: if (fire) begin
          cmd_q  <= C_MRS;
          addr_q <= MODE_WORD;
          gap    <= GAP_W'(TMRD - 1);
          state  <= S_SETTLE;
        end
        S_SETTLE: if (gap == '0) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
        end
        S_IDLE:
          if (owed != '0)     state <= S_AREF;
          else if (sleep_req) state <= S_SREN;
        S_AREF: if (fire) begin
          cmd_q <= C_AREF;
          gap   <= GAP_W'(TRC - 1);
          if (owed_nx == '0) state <= S_SETTLE;
        end
        S_SREN: if (fire) begin
          cmd_q <= C_AREF;
          cke_q <= 1'b0;
          state <= S_SELF;
        end
        S_SELF: if (!sleep_req) begin
          cke_q <= 1'b1;
          gap   <= GAP_W'(TRC + 1);
          state <= S_SETTLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd  = cmd_q;
  assign addr = addr_q;
  assign cke  = cke_q;
  assign done = done_q;
  assign busy = (state != S_IDLE) || (owed != '0);
endmodule

// File: rtl/sdram_upkeep_chk.sv
module sdram_upkeep_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MODE = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grant,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              cke,
  input logic              done,
  input logic              busy
);
  p_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != 4'b0111 |-> $past(grant));
  p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_mode_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0000 |-> addr == MODE);
  p_pall_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0010 |-> (!done && addr[10]));
  p_self_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> cmd == 4'b0001);
  p_self_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> cmd == 4'b0111);
  p_sleep_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> busy);
  p_no_early_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> cke);
endmodule

bind sdram_upkeep_seq sdram_upkeep_chk #(.ADDR_W(ADDR_W), .MODE(MODE_WORD)) chk_i (
  .clk(clk), .rst_n(rst_n), .grant(grant), .cmd(cmd), .addr(addr),
  .cke(cke), .done(done), .busy(busy));

// File: tb/sdram_upkeep_seq_tb_top.sv
module sdram_upkeep_seq_tb_top;
  localparam int INIT_WAIT = 30, REFI = 150, TRC = 8, TRP = 3, TMRD = 2;
  localparam int INIT_REFS = 8, MAX_OWED = 4, ADDR_W = 12;
  localparam logic [11:0] MODE = 12'h02A;
  localparam logic [3:0] NOP = 4'b0111, PALL = 4'b0010, AREF = 4'b0001, MRS = 4'b0000;

  logic clk = 0, rst_n = 0, grant = 0, sleep_req = 1;
  logic [3:0] cmd; logic [ADDR_W-1:0] addr; logic cke, done, busy;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sdram_upkeep_seq #(.INIT_WAIT(INIT_WAIT), .REFI(REFI), .TRC(TRC), .TRP(TRP),
    .TMRD(TMRD), .INIT_REFS(INIT_REFS), .MAX_OWED(MAX_OWED), .ADDR_W(ADDR_W),
    .CAS_LAT(2), .BURST_LEN(4), .INTERLEAVE(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .grant(grant), .sleep_req(sleep_req),
    .cmd(cmd), .addr(addr), .cke(cke), .done(done), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: phases 0 pre,1 init-ref,2 mode,3 settle,4 idle,5 refresh,6 sleep-entry,7 asleep
  int n, allow, ph, left, owed, next_tick;
  bit m_done, m_cke;
  logic [3:0] e_cmd; logic [11:0] e_addr;
  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; allow = INIT_WAIT; ph = 0; left = 0; owed = 0; next_tick = -1;
      m_done = 0; m_cke = 1; e_cmd = NOP; e_addr = 0;
    end else begin
      bit fire, inc, issued;
      fire = (n >= allow) && grant;
      inc = m_done && m_cke && (n == next_tick);
      issued = 0; e_cmd = NOP; e_addr = 0;
      case (ph)
        0: if (fire) begin e_cmd = PALL; e_addr = 12'h400; allow = n + TRP; left = INIT_REFS; ph = 1; end
        1: if (fire) begin e_cmd = AREF; allow = n + TRC; left--; if (left == 0) ph = 2; end
        2: if (fire) begin e_cmd = MRS; e_addr = MODE; allow = n + TMRD; ph = 3; end
        3: if (n >= allow) begin ph = 4; if (!m_done) begin m_done = 1; next_tick = n + REFI; end end
        4: if (owed > 0) ph = 5; else if (sleep_req) ph = 6;
        5: if (fire) begin e_cmd = AREF; allow = n + TRC; owed--; issued = 1; end
        6: if (fire) begin e_cmd = AREF; m_cke = 0; ph = 7; owed = 0; inc = 0; end
        default: if (!sleep_req) begin m_cke = 1; allow = n + TRC + 2; ph = 3; next_tick = n + REFI; end
      endcase
      if (inc) begin
        if (owed < MAX_OWED) owed++;
        next_tick += REFI;
      end
      if (ph == 5 && issued && owed == 0) ph = 3;
      n++;
    end
  end

  function automatic string tag_of(input int p);
    case (p)
      0, 1: return "R2";
      2, 3: return "R3";
      4:    return "R5";
      5:    return "R6";
      default: return "R7";
    endcase
  endfunction

  // port monitor
  int cyc = 0, ref_cnt = 0, last_ref = 0, ref_gap = 0, pall_cnt = 0, init_refs = 0;
  int early_cmds = 0, nogrant_cmds = 0;
  bit mrs_seen = 0, g_edge = 0; logic [11:0] mrs_addr = 0;
  always @(posedge clk) g_edge <= grant;
  always @(negedge clk) if (rst_n) begin
    cyc++;
    chk(cmd == e_cmd && addr == e_addr, tag_of(ph), {cmd, addr}, {e_cmd, e_addr});
    chk(cke == m_cke && done == m_done, tag_of(ph), {cke, done}, {m_cke, m_done});
    chk(busy == ((ph != 4) || (owed != 0)), "R5", busy, (ph != 4) || (owed != 0));
    if (cmd != NOP && !g_edge) nogrant_cmds++;
    if (cmd != NOP && cyc <= INIT_WAIT) early_cmds++;
    if (cmd == PALL) pall_cnt++;
    if (cmd == AREF && !done) init_refs++;
    if (cmd == MRS) begin mrs_seen = 1; mrs_addr = addr; end
    if (cmd == AREF && cke) begin ref_gap = cyc - last_ref; last_ref = cyc; ref_cnt++; end
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  bit pre_done_cke_low = 0;
  always @(negedge clk) if (rst_n && !done && !cke) pre_done_cke_low = 1;

  initial begin
    int b;
    repeat (3) @(negedge clk);
    chk(cmd == NOP && cke && !done && busy, "R1 reset state", {cmd, cke, done, busy}, {NOP, 3'b101});
    rst_n = 1;
    repeat (INIT_WAIT + 5) @(negedge clk);
    chk(early_cmds == 0 && pall_cnt == 0, "R4 no command without grant", pall_cnt, 0);
    grant = 1;
    wait (mrs_seen);
    @(negedge clk); sleep_req = 0;
    while (!done) @(negedge clk);
    chk(pall_cnt == 1, "R2 single precharge-all", pall_cnt, 1);
    chk(init_refs == INIT_REFS, "R2 start-up refresh count", init_refs, INIT_REFS);
    chk(mrs_addr == MODE, "R3 mode word", mrs_addr, MODE);
    chk(!pre_done_cke_low, "R9 sleep ignored before done", pre_done_cke_low, 0);
    b = ref_cnt; repeat (2 * REFI + 20) @(negedge clk);
    chk(ref_cnt - b == 2, "R5 periodic refresh count", ref_cnt - b, 2);
    grant = 0; repeat (2 * REFI) @(negedge clk);
    b = ref_cnt; grant = 1; repeat (3 * TRC + 5) @(negedge clk);
    chk(ref_cnt - b == 2, "R6 catch-up count", ref_cnt - b, 2);
    chk(ref_gap == TRC, "R6 back-to-back spacing", ref_gap, TRC);
    grant = 0; repeat (6 * REFI) @(negedge clk);
    b = ref_cnt; grant = 1; repeat (MAX_OWED * TRC + 10) @(negedge clk);
    chk(ref_cnt - b == MAX_OWED, "R10 saturated repayment", ref_cnt - b, MAX_OWED);
    chk(nogrant_cmds == 0, "R4 commands only after grant", nogrant_cmds, 0);
    sleep_req = 1;
    while (cke) @(negedge clk);
    b = ref_cnt; repeat (3 * REFI) @(negedge clk);
    chk(!cke && ref_cnt == b, "R7 quiet in self refresh", ref_cnt - b, 0);
    sleep_req = 0;
    while (!cke) @(negedge clk);
    for (int k = 0; k < TRC + 2; k++) begin
      chk(busy && cmd == NOP, "R8 exit window holds bus", {busy, cmd}, {1'b1, NOP});
      @(negedge clk);
    end
    chk(!busy, "R8 bus released after exit window", busy, 0);
    chk(!busy, "R7 owed count cleared on entry", busy, 0);
    b = ref_cnt; repeat (REFI + 10) @(negedge clk);
    chk(ref_cnt - b == 1, "R5 cadence resumes after exit", ref_cnt - b, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule